// File: doc/BRIEF.md
# Management-Link Power-On Synchroniser

This block brings the three-wire handshake link to a system-management microcontroller into a known idle state after power-up. The link uses three wires: a request line driven by the controller, and acknowledge and in-progress lines driven by this block. A separate shift-register port reports each completed byte through a flag input, which the block clears with a read strobe. A `start` pulse runs the sequence. It ends with a one-cycle `done` pulse, or with an `err` pulse if the controller never answers. Normal packet traffic is handled elsewhere and begins only after `done`.

Two controller generations are supported, and `older_mode` selects between them. The default generation uses active-low acknowledge and in-progress lines. It runs a settle delay followed by a four-phase acknowledge/request exchange, and each wait in that exchange is polled on a fixed interval with a bounded number of polls. The older generation uses active-high lines and paces each edge with fixed microsecond delays. It also cleans up a transfer that was left open. An inbound transfer is drained byte by byte. An outbound transfer is closed with a final acknowledge.

All timing comes from a 1 µs tick, produced by dividing the clock by `CLK_DIV`.

Top module: `link_sync_seq`

## Requirements
- R1: When `start` is seen while the block is idle, `cfg_req` and `sr_read` each pulse for exactly one cycle. Acknowledge is negated. In-progress is negated, except in older mode when `tip_sense` reports it asserted, in which case it is kept asserted.
- R2: In default mode, `T_SETTLE_US` µs after the start pulse, `sr_read` pulses and acknowledge is asserted in the same cycle. In-progress stays negated for the whole default sequence.
- R3: In default mode, the block waits for request to be asserted (`req_n` = 0) and then for `byte_flag`. When the flag is seen, it pulses `sr_read` and negates acknowledge in the same cycle.
- R4: In default mode, the block next waits for request to be negated and then for `byte_flag`. It then pulses `done` and `sr_read` together in the same cycle.
- R5: Each default-mode wait samples its condition on entry and then every `POLL_US` µs. After `POLL_LIMIT` further failed samples, `err` pulses, both outputs are negated and the block returns to idle. This happens `POLL_LIMIT*POLL_US` µs after the wait began.
- R6: Pin sense depends on the mode. In default mode an asserted line is 0 and a negated line is 1. In older mode an asserted line is 1. `req_n` is active low in both modes.
- R7: In older mode, if request is asserted at start, the block drains the inbound transfer in these steps:
  - After 450-class `T_SESS_US`, it asserts both outputs.
  - It then repeats a loop: after `T_ACK_OFF_US` it negates acknowledge; after `T_DRAIN_US` it pulses `sr_read`; after `T_ACK_ON_US` it asserts acknowledge. At that point, if request is still asserted, the loop runs again.
  - When request is no longer asserted, it negates both outputs after `T_ACK_OFF_US`, and then finishes.
- R8: In older mode, if request is not asserted but in-progress is, the block closes the outbound transfer in these steps:
  - After `T_ACK_OFF_US` it negates acknowledge.
  - After `T_ACK_ON_US` it asserts acknowledge.
  - It holds for `T_DRAIN_US`.
  - After `T_ACK_OFF_US` it negates both outputs, and then finishes.
- R9: In older mode, the finishing cycle pulses `done`. It also pulses `sr_read` in that same cycle if `byte_flag` is set. With nothing pending at start, `done` follows the start pulse by one cycle.
- R10: `done` and `err` are single-cycle pulses and never occur together. A `start` pulse that arrives while a sequence is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin synchronisation (sampled when idle) |
| older_mode | input | 1 | 1 selects the older controller generation |
| req_n | input | 1 | Request line from the controller, active low |
| tip_sense | input | 1 | Readback level of the in-progress line |
| byte_flag | input | 1 | Shift-register byte-complete flag |
| ack_pin | output | 1 | Acknowledge line level |
| tip_pin | output | 1 | In-progress line level |
| cfg_req | output | 1 | Pulse: set pin directions and shift-in on external clock |
| sr_read | output | 1 | Pulse: read shift register, clearing `byte_flag` |
| done | output | 1 | Pulse: synchronisation complete |
| err | output | 1 | Pulse: a wait timed out |

## Verification
The shift-register read strobe can coincide with completion. The final flag clear and `done` share one cycle in the default exchange, and also in the older close-out when a byte is pending. The bench provokes the default case by raising the flag during the last wait. It provokes the older case by setting the flag before closing an outbound transfer. The monitor records every cycle in which any strobe or line changes as a single event, so the expected item must match both strobes at once. Spacing between events is also compared against the pacing delays.

// File: rtl/link_sync_seq.sv
module link_sync_seq #(
  parameter int CLK_DIV      = 50,
  parameter int T_SETTLE_US  = 4000,
  parameter int POLL_US      = 100,
  parameter int POLL_LIMIT   = 1000,
  parameter int T_SESS_US    = 450,
  parameter int T_ACK_ON_US  = 400,
  parameter int T_ACK_OFF_US = 300,
  parameter int T_DRAIN_US   = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic older_mode,
  input  logic req_n,
  input  logic tip_sense,
  input  logic byte_flag,
  output logic ack_pin,
  output logic tip_pin,
  output logic cfg_req,
  output logic sr_read,
  output logic done,
  output logic err
);
  localparam int MAXD = T_SETTLE_US + T_DRAIN_US + T_SESS_US + T_ACK_ON_US + T_ACK_OFF_US;
  localparam int US_W = $clog2(MAXD + 1);
  localparam int DV_W = $clog2(CLK_DIV + 1);
  localparam int PC_W = $clog2(POLL_US + 1);
  localparam int NP_W = $clog2(POLL_LIMIT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_SETTLE, S_WREQ, S_WFLG1, S_WNREQ, S_WFLG2,
    S_SESS, S_DNEG, S_DHOLD, S_DACK, S_TNEG, S_TACK, S_THOLD, S_END, S_FIN
  } st_t;

  st_t st_q, st_d;
  logic a_q, t_q, a_d, t_d;
  logic cfg_d, rd_d, done_d, err_d;
  logic [DV_W-1:0] div_q;
  logic [US_W-1:0] us_q;
  logic [PC_W-1:0] pc_q;
  logic [NP_W-1:0] np_q;
  logic fresh_q;

  wire moved    = (st_d != st_q);
  wire tick     = (div_q == DV_W'(CLK_DIV - 1));
  wire poll     = fresh_q || (tick && pc_q == PC_W'(POLL_US - 1));
  wire tip_seen = older_mode ? tip_sense : ~tip_sense;
  wire in_wait  = (st_q == S_WREQ) || (st_q == S_WFLG1) || (st_q == S_WNREQ) || (st_q == S_WFLG2);

  logic cond;
  always_comb begin
    case (st_q)
      S_WREQ:  cond = ~req_n;
      S_WNREQ: cond = req_n;
      default: cond = byte_flag;
    endcase
  end

  wire hit     = in_wait && poll && cond;
  wire timeout = in_wait && poll && !cond && (np_q == NP_W'(POLL_LIMIT));

  function automatic logic elapsed(input logic [US_W-1:0] us, input int n);
    return us == US_W'(n);
  endfunction

  always_comb begin
    st_d = st_q; a_d = a_q; t_d = t_q;
    cfg_d = 1'b0; rd_d = 1'b0; done_d = 1'b0; err_d = 1'b0;
    case (st_q)
      S_IDLE: if (start) begin
        cfg_d = 1'b1; rd_d = 1'b1; a_d = 1'b0;
        t_d = older_mode & tip_seen;
        if (!older_mode)  st_d = S_SETTLE;
        else if (!req_n)  st_d = S_SESS;
        else if (tip_seen) st_d = S_TNEG;
        else              st_d = S_FIN;
      end
      S_SETTLE: if (elapsed(us_q, T_SETTLE_US)) begin rd_d = 1'b1; a_d = 1'b1; st_d = S_WREQ; end
      S_WREQ:   if (hit) st_d = S_WFLG1;
      S_WFLG1:  if (hit) begin rd_d = 1'b1; a_d = 1'b0; st_d = S_WNREQ; end
      S_WNREQ:  if (hit) st_d = S_WFLG2;
      S_WFLG2:  if (hit) st_d = S_FIN;
      S_SESS:   if (elapsed(us_q, T_SESS_US)) begin a_d = 1'b1; t_d = 1'b1; st_d = S_DNEG; end
      S_DNEG:   if (elapsed(us_q, T_ACK_OFF_US)) begin a_d = 1'b0; st_d = S_DHOLD; end
      S_DHOLD:  if (elapsed(us_q, T_DRAIN_US)) begin rd_d = 1'b1; st_d = S_DACK; end
      S_DACK:   if (elapsed(us_q, T_ACK_ON_US)) begin a_d = 1'b1; st_d = req_n ? S_END : S_DNEG; end
      S_TNEG:   if (elapsed(us_q, T_ACK_OFF_US)) begin a_d = 1'b0; st_d = S_TACK; end
      S_TACK:   if (elapsed(us_q, T_ACK_ON_US)) begin a_d = 1'b1; st_d = S_THOLD; end
      S_THOLD:  if (elapsed(us_q, T_DRAIN_US)) st_d = S_END;
      S_END:    if (elapsed(us_q, T_ACK_OFF_US)) begin a_d = 1'b0; t_d = 1'b0; st_d = S_FIN; end
      S_FIN: begin done_d = 1'b1; rd_d = byte_flag; st_d = S_IDLE; end
      default: st_d = S_IDLE;
    endcase
    if (timeout) begin
      err_d = 1'b1; a_d = 1'b0; t_d = 1'b0; st_d = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; a_q <= 1'b0; t_q <= 1'b0;
      cfg_req <= 1'b0; sr_read <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      st_q <= st_d; a_q <= a_d; t_q <= t_d;
      cfg_req <= cfg_d; sr_read <= rd_d; done <= done_d; err <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0; us_q <= '0; pc_q <= '0; np_q <= '0; fresh_q <= 1'b1;
    end else if (moved) begin
      div_q <= '0; us_q <= '0; pc_q <= '0; np_q <= '0; fresh_q <= 1'b1;
    end else begin
      fresh_q <= 1'b0;
      div_q   <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        us_q <= us_q + 1'b1;
        pc_q <= (pc_q == PC_W'(POLL_US - 1)) ? '0 : pc_q + 1'b1;
      end
      if (in_wait && poll && !cond) np_q <= np_q + 1'b1;
    end
  end

  assign ack_pin = older_mode ? a_q : ~a_q;
  assign tip_pin = older_mode ? t_q : ~t_q;

  assert_start_strobes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && start) |=> (cfg_req && sr_read));
  assert_no_tip_default_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!older_mode && $stable(older_mode)) |-> tip_pin);
  assert_err_negates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (ack_pin == ~older_mode && tip_pin == ~older_mode));
  assert_poll_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    np_q <= NP_W'(POLL_LIMIT));
  assert_done_err_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE && start) |=> !cfg_req);
endmodule

// File: tb/test_link_sync_seq.sv
module test_link_sync_seq;
  localparam int CLK_PERIOD = 10;
  localparam int D = 2, SET = 40, P = 5, L = 6, SESS = 9, ON = 8, OFF = 6, DR = 20;

  logic clk = 0, rst_n = 0, start = 0, older = 0, req_n = 1, tip_sense = 0;
  logic flag, flag_set = 0;
  logic ack_pin, tip_pin, cfg_req, sr_read, done, err;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_sync_seq #(.CLK_DIV(D), .T_SETTLE_US(SET), .POLL_US(P), .POLL_LIMIT(L),
    .T_SESS_US(SESS), .T_ACK_ON_US(ON), .T_ACK_OFF_US(OFF), .T_DRAIN_US(DR)) i_link_sync_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .older_mode(older), .req_n(req_n),
    .tip_sense(tip_sense), .byte_flag(flag), .ack_pin(ack_pin), .tip_pin(tip_pin),
    .cfg_req(cfg_req), .sr_read(sr_read), .done(done), .err(err));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag <= 1'b0;
    else if (sr_read) flag <= 1'b0;
    else if (flag_set) flag <= 1'b1;

  typedef struct { logic [5:0] v; int gap; string tag; } ev_t;
  ev_t q[$];
  int errors = 0, checks = 0, cyc = 0, last_cyc = 0;
  logic mon_en = 0, pa = 1, pt = 1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic pin(input logic asserted);
    return older ? asserted : ~asserted;
  endfunction

  task automatic expect_ev(input logic c, r, a, t, dn, er, input int gap, input string tag);
    ev_t e;
    e.v = {c, r, pin(a), pin(t), dn, er};
    e.gap = gap; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && mon_en && (cfg_req || sr_read || done || err || ack_pin != pa || tip_pin != pt)) begin
      logic [5:0] got;
      got = {cfg_req, sr_read, ack_pin, tip_pin, done, err};
      if (q.size() == 0) chk(0, "R10", "unexpected event", got, 0);
      else begin
        ev_t e;
        e = q.pop_front();
        chk(got == e.v, e.tag, "event", got, e.v);
        if (e.gap > 0) chk((cyc - last_cyc) >= e.gap - 1 && (cyc - last_cyc) <= e.gap + 1,
                           e.tag, "gap", cyc - last_cyc, e.gap);
      end
      last_cyc = cyc;
    end
    pa = ack_pin; pt = tip_pin;
  end

  task automatic pulse_start();
    @(negedge clk) start = 1; @(negedge clk) start = 0;
  endtask
  task automatic pulse_flag();
    @(negedge clk) flag_set = 1; @(negedge clk) flag_set = 0;
  endtask
  task automatic wait_end(input string tag);
    int n;
    n = 0;
    while (!(done || err) && n < 5000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    chk(q.size() == 0, tag, "events left", q.size(), 0);
    q.delete();
  endtask
  task automatic set_mode(input logic m);
    mon_en = 0; older = m; @(negedge clk); @(negedge clk); mon_en = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ack_pin == 1 && tip_pin == 1, "R6", "reset pins", {ack_pin, tip_pin}, 2'b11);
    chk(!done && !err && !cfg_req && !sr_read, "R1", "reset strobes",
        {cfg_req, sr_read, done, err}, 0);
    mon_en = 1;

    // default exchange, with a stray start while busy (R10)
    expect_ev(1,1,0,0,0,0, 0, "R1");
    expect_ev(0,1,1,0,0,0, SET*D+1, "R2");
    expect_ev(0,1,0,0,0,0, 0, "R3");
    expect_ev(0,1,0,0,1,0, 0, "R4");
    pulse_start();
    repeat (10) @(negedge clk);
    pulse_start();
    wait (ack_pin == 0);
    repeat (7) @(negedge clk); req_n = 0;
    repeat (13) @(negedge clk); pulse_flag();
    wait (ack_pin == 1);
    repeat (4) @(negedge clk); req_n = 1;
    repeat (9) @(negedge clk); pulse_flag();
    wait_end("R4");

    // default timeout: request never comes
    expect_ev(1,1,0,0,0,0, 0, "R1");
    expect_ev(0,1,1,0,0,0, SET*D+1, "R2");
    expect_ev(0,0,0,0,0,1, L*P*D, "R5");
    pulse_start();
    wait_end("R5");

    // older: drain inbound transfer over two bytes
    set_mode(1);
    req_n = 0; tip_sense = 0;
    expect_ev(1,1,0,0,0,0, 0, "R7");
    expect_ev(0,0,1,1,0,0, SESS*D+1, "R7");
    expect_ev(0,0,0,1,0,0, OFF*D+1, "R7");
    expect_ev(0,1,0,1,0,0, DR*D+1, "R7");
    expect_ev(0,0,1,1,0,0, ON*D+1, "R7");
    expect_ev(0,0,0,1,0,0, OFF*D+1, "R7");
    expect_ev(0,1,0,1,0,0, DR*D+1, "R7");
    expect_ev(0,0,1,1,0,0, ON*D+1, "R7");
    expect_ev(0,0,0,0,0,0, OFF*D+1, "R7");
    expect_ev(0,0,0,0,1,0, 1, "R9");
    pulse_start();
    begin
      int n;
      n = 0;
      while (n < 2) begin @(negedge clk); if (sr_read) n++; end
    end
    req_n = 1;
    wait_end("R7");

    // older: close open outbound transfer, byte pending at finish
    tip_sense = 1;
    expect_ev(1,1,0,1,0,0, 0, "R8");
    expect_ev(0,0,1,1,0,0, OFF*D+1 + ON*D+1, "R8");
    expect_ev(0,0,0,0,0,0, DR*D+1 + OFF*D+1, "R8");
    expect_ev(0,1,0,0,1,0, 1, "R9");
    pulse_start();
    repeat (5) @(negedge clk); pulse_flag();
    wait_end("R8");

    // older: nothing pending
    tip_sense = 0;
    expect_ev(1,1,0,0,0,0, 0, "R1");
    expect_ev(0,0,0,0,1,0, 1, "R9");
    pulse_start();
    wait_end("R9");

    // back to default, polarity restored
    set_mode(0);
    @(negedge clk);
    chk(ack_pin == 1 && tip_pin == 1, "R6", "default idle pins", {ack_pin, tip_pin}, 2'b11);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule